// File: doc/BRIEF.md
# Vectored Interrupt and Trap Priority Controller

This block decides which exception a small processor core takes next. Each maskable source presents a request flag, an enable bit and a three-bit user level. A small set of non-maskable trap inputs sits above all of them. The controller compares the best pending request against the current CPU priority. At an instruction-boundary strobe it raises a take strobe and gives the vector number and the fetch address from either of two vector tables.

The controller owns the CPU priority. On every entry it pushes the old level onto an internal LIFO, and on a return strobe it pops that level back. Software may write the priority directly, unless the global nesting-disable control is set. In that mode any maskable entry parks the CPU at level 7, and software writes are ignored. The user levels then only pick among requests that are pending together. Trap entry moves the CPU to an internal level 8, so maskable sources stay blocked until the trap handler returns.

Maskable source i uses vector 8 + i. Trap vectors 1 to 5 are, from highest to lowest, oscillator failure, address error, stack error, math error and DMA error.

Top module: `ivc_top`

## Requirements
- R1: A source whose user level is 0 is never taken. Among enabled, flagged sources the one with the highest level (7 highest, 1 lowest) wins.
- R2: Among winners of equal level the lowest source index wins. The reported vector is 8 + source index.
- R3: With nesting enabled, a maskable winner is taken only if its level is strictly above cpu_lvl. Entry sets cpu_lvl to the winner's level.
- R4: With nest_dis high, a maskable entry sets cpu_lvl to 7. No maskable source is then taken until a return.
- R5: A priority write (ipl_wr) loads cpu_lvl from ipl_wdata when nest_dis is low. It is ignored when nest_dis is high.
- R6: A pending trap is taken ahead of any maskable request at any cpu_lvl, including level 8, so traps nest. The lowest pending trap vector (trap_in bit k is vector k+1) wins, and trap entry sets cpu_lvl to 8.
- R7: exc_addr equals the table base plus twice exc_vec. The base is 0x000004 with alt_sel low and 0x000084 with alt_sel high.
- R8: A return strobe restores the level that was current before the matching entry, in LIFO order over at least 8 levels. A return with nothing stacked sets cpu_lvl to 0.
- R9: A trap_in pulse is held pending until it is taken, and a flag counts as a request only while its enable bit is set.
- R10: exc_take is high only in a cycle with boundary high. After reset cpu_lvl is 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_flag | input | N_SRC | Request flag per maskable source |
| irq_en | input | N_SRC | Enable per maskable source |
| irq_lvl | input | 3*N_SRC | User level per source, source i in bits [3i+2:3i] |
| trap_in | input | 5 | Trap condition pulses, bit k is vector k+1 |
| nest_dis | input | 1 | Global nesting-disable control |
| alt_sel | input | 1 | Selects the alternate vector table |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| rtn | input | 1 | Return-from-exception strobe |
| ipl_wr | input | 1 | Software write of the CPU priority |
| ipl_wdata | input | 3 | Value for the priority write |
| exc_take | output | 1 | Exception entry strobe |
| exc_vec | output | 8 | Winning vector number |
| exc_addr | output | 24 | Vector fetch address |
| cpu_lvl | output | 4 | Current CPU priority (8 means trap handler) |

## Verification
The arbiter is tried with these request patterns:
- Equal-level pairs, to separate the index tie-break from the level comparison.
- Mixed levels, to show that level outranks index.
- A level-0 source and a flagged but disabled source, to show what never counts as a request.
- A request equal to the CPU level against one above it, to pin down the strictly-greater rule.

Two traps are pulsed in the same cycle while a level-7 request is waiting. This shows the fixed trap order, trap-over-interrupt precedence and nested trap entry. The return chain then shows the LIFO order. Runs with nesting disabled and with the alternate table show the locked priority and the second address base.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int NUM_TRAPS   = 5;
    localparam int LVL_W       = 4;
    localparam int ULVL_W      = 3;
    localparam int VEC_W       = 8;
    localparam int ADDR_W      = 24;
    localparam int TRAP_SEL_W  = $clog2(NUM_TRAPS);

    localparam logic [ADDR_W-1:0] PRI_BASE      = 24'h000004;
    localparam logic [ADDR_W-1:0] ALT_BASE      = 24'h000084;
    localparam logic [VEC_W-1:0]  MASK_VEC_BASE = 8'd8;
    localparam logic [LVL_W-1:0]  TRAP_LEVEL    = 4'd8;
    localparam logic [LVL_W-1:0]  LOCK_LEVEL    = 4'd7;

    typedef struct packed {
        logic              valid;
        logic              is_trap;
        logic [VEC_W-1:0]  vec;
        logic [LVL_W-1:0]  lvl;
    } winner_t;

    function automatic logic [ADDR_W-1:0] vector_address(input logic alt, input logic [VEC_W-1:0] vec);
        logic [ADDR_W-1:0] base;
        base = alt ? ALT_BASE : PRI_BASE;
        return base + {{(ADDR_W-VEC_W-1){1'b0}}, vec, 1'b0};
    endfunction
endpackage

// File: rtl/ivc_mask_arb.sv
module ivc_mask_arb
    import ivc_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic [N_SRC-1:0]          req,
    input  logic [ULVL_W*N_SRC-1:0]   lvl,
    output logic                      valid,
    output logic [VEC_W-1:0]          vec,
    output logic [ULVL_W-1:0]         win_lvl
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [IDX_W-1:0]  best_idx;
    logic [ULVL_W-1:0] best_lvl;

    always_comb begin
        best_idx = '0;
        best_lvl = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && (lvl[i*ULVL_W +: ULVL_W] > best_lvl)) begin
                best_lvl = lvl[i*ULVL_W +: ULVL_W];
                best_idx = IDX_W'(i);
            end
        end
    end

    assign valid   = (best_lvl != '0);
    assign win_lvl = best_lvl;
    assign vec     = VEC_W'(best_idx) + MASK_VEC_BASE;
endmodule

// File: rtl/ivc_trap_latch.sv
module ivc_trap_latch
    import ivc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_TRAPS-1:0]  trap_in,
    input  logic                  take_trap,
    output logic                  any,
    output logic [VEC_W-1:0]      vec
);
    logic [NUM_TRAPS-1:0]  pend_q;
    logic [TRAP_SEL_W-1:0] sel;
    logic [NUM_TRAPS-1:0]  clr;

    always_comb begin
        sel = '0;
        for (int i = NUM_TRAPS - 1; i >= 0; i--) begin
            if (pend_q[i]) sel = TRAP_SEL_W'(i);
        end
    end

    assign any = |pend_q;
    assign vec = VEC_W'(sel) + VEC_W'(1);
    assign clr = take_trap ? (NUM_TRAPS'(1) << sel) : '0;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr) | trap_in;
    end
endmodule

// File: rtl/ivc_lvl_stack.sv
module ivc_lvl_stack
    import ivc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] din,
    output logic [LVL_W-1:0] top,
    output logic             empty
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LVL_W-1:0] mem [DEPTH];
    logic [PW-1:0]    ptr;
    logic             full;

    assign empty = (ptr == '0);
    assign full  = (ptr == PW'(DEPTH));
    assign top   = empty ? '0 : mem[IW'(ptr - 1'b1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (push && !full) begin
            mem[IW'(ptr)] <= din;
            ptr           <= ptr + 1'b1;
        end else if (pop && !empty) begin
            ptr <= ptr - 1'b1;
        end
    end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int N_SRC       = 16,
    parameter int STACK_DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        irq_flag,
    input  logic [N_SRC-1:0]        irq_en,
    input  logic [3*N_SRC-1:0]      irq_lvl,
    input  logic [4:0]              trap_in,
    input  logic                    nest_dis,
    input  logic                    alt_sel,
    input  logic                    boundary,
    input  logic                    rtn,
    input  logic                    ipl_wr,
    input  logic [2:0]              ipl_wdata,
    output logic                    exc_take,
    output logic [7:0]              exc_vec,
    output logic [23:0]             exc_addr,
    output logic [3:0]              cpu_lvl
);
    logic [N_SRC-1:0]        req_q;
    logic [3*N_SRC-1:0]      lvl_q;
    logic                    mask_valid;
    logic [VEC_W-1:0]        mask_vec;
    logic [ULVL_W-1:0]       win_lvl;
    logic                    trap_any;
    logic [VEC_W-1:0]        trap_vec;
    winner_t                 win;
    logic                    win_is_trap;
    logic [LVL_W-1:0]        lvl_q4;
    logic [LVL_W-1:0]        stk_top;
    logic                    stk_empty;
    logic [LVL_W-1:0]        entry_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            lvl_q <= '0;
        end else begin
            req_q <= irq_flag & irq_en;
            lvl_q <= irq_lvl;
        end
    end

    ivc_mask_arb #(.N_SRC(N_SRC)) arb_i (
        .req     (req_q),
        .lvl     (lvl_q),
        .valid   (mask_valid),
        .vec     (mask_vec),
        .win_lvl (win_lvl)
    );

    ivc_trap_latch trap_i (
        .clk       (clk),
        .rst       (rst),
        .trap_in   (trap_in),
        .take_trap (exc_take && win_is_trap),
        .any       (trap_any),
        .vec       (trap_vec)
    );

    always_comb begin
        if (trap_any) begin
            win.valid   = 1'b1;
            win.is_trap = 1'b1;
            win.vec     = trap_vec;
            win.lvl     = TRAP_LEVEL;
        end else begin
            win.is_trap = 1'b0;
            win.vec     = mask_vec;
            win.lvl     = {1'b0, win_lvl};
            win.valid   = mask_valid && ({1'b0, win_lvl} > lvl_q4);
        end
    end

    assign win_is_trap = win.is_trap;
    assign exc_take    = boundary && win.valid;
    assign exc_vec     = win.vec;
    assign exc_addr    = vector_address(alt_sel, win.vec);
    assign entry_lvl   = win.is_trap ? TRAP_LEVEL : (nest_dis ? LOCK_LEVEL : win.lvl);

    ivc_lvl_stack #(.DEPTH(STACK_DEPTH)) stk_i (
        .clk   (clk),
        .rst   (rst),
        .push  (exc_take),
        .pop   (rtn && !exc_take),
        .din   (lvl_q4),
        .top   (stk_top),
        .empty (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q4 <= '0;
        end else if (exc_take) begin
            lvl_q4 <= entry_lvl;
        end else if (rtn) begin
            lvl_q4 <= stk_empty ? '0 : stk_top;
        end else if (ipl_wr && !nest_dis) begin
            lvl_q4 <= {1'b0, ipl_wdata};
        end
    end

    assign cpu_lvl = lvl_q4;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker (
    input logic       clk,
    input logic       rst,
    input logic       take,
    input logic       is_trap,
    input logic       nest_dis,
    input logic       ipl_wr,
    input logic       rtn,
    input logic       boundary,
    input logic       trap_any,
    input logic [2:0] win_lvl,
    input logic [3:0] cpu_lvl
);
    a_r1_level_zero_never: assert property (@(posedge clk) disable iff (rst)
        (take && !is_trap) |-> (win_lvl != 3'd0));

    a_r3_entry_raises: assert property (@(posedge clk) disable iff (rst)
        (take && !is_trap) |=> (cpu_lvl > $past(cpu_lvl)));

    a_r4_lock_at_seven: assert property (@(posedge clk) disable iff (rst)
        (take && !is_trap && nest_dis) |=> (cpu_lvl == 4'd7));

    a_r5_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (ipl_wr && nest_dis && !take && !rtn) |=> $stable(cpu_lvl));

    a_r6_trap_entry: assert property (@(posedge clk) disable iff (rst)
        (trap_any && boundary) |=> (cpu_lvl == 4'd8));
endmodule

bind ivc_top ivc_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .take     (exc_take),
    .is_trap  (win_is_trap),
    .nest_dis (nest_dis),
    .ipl_wr   (ipl_wr),
    .rtn      (rtn),
    .boundary (boundary),
    .trap_any (trap_any),
    .win_lvl  (win_lvl),
    .cpu_lvl  (cpu_lvl)
);

// File: tb/ivc_top_tb_top.sv
module ivc_top_tb_top;
    localparam int N = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    irq_flag;
    logic [N-1:0]    irq_en;
    logic [3*N-1:0]  irq_lvl;
    logic [4:0]      trap_in;
    logic            nest_dis, alt_sel, boundary, rtn, ipl_wr;
    logic [2:0]      ipl_wdata;
    logic            exc_take;
    logic [7:0]      exc_vec;
    logic [23:0]     exc_addr;
    logic [3:0]      cpu_lvl;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ivc_top #(.N_SRC(N), .STACK_DEPTH(8)) dut_i (
        .clk(clk), .rst(rst), .irq_flag(irq_flag), .irq_en(irq_en), .irq_lvl(irq_lvl),
        .trap_in(trap_in), .nest_dis(nest_dis), .alt_sel(alt_sel), .boundary(boundary),
        .rtn(rtn), .ipl_wr(ipl_wr), .ipl_wdata(ipl_wdata), .exc_take(exc_take),
        .exc_vec(exc_vec), .exc_addr(exc_addr), .cpu_lvl(cpu_lvl)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_src(int i, int lvl, bit flag, bit en);
        irq_lvl[i*3 +: 3] = 3'(lvl);
        irq_flag[i] = flag;
        irq_en[i]   = en;
    endtask

    task automatic fire(string tag, bit exp_take, int exp_vec, int exp_addr, int exp_lvl);
        @(negedge clk);
        boundary = 1'b1;
        #1;
        chk({tag, " take"}, int'(exc_take), int'(exp_take));
        if (exp_take) begin
            chk({tag, " vec"}, int'(exc_vec), exp_vec);
            chk({tag, " R7 addr"}, int'(exc_addr), exp_addr);
        end
        @(negedge clk);
        boundary = 1'b0;
        #1;
        chk({tag, " cpu_lvl"}, int'(cpu_lvl), exp_lvl);
    endtask

    task automatic do_return(string tag, int exp_lvl);
        @(negedge clk);
        rtn = 1'b1;
        @(negedge clk);
        rtn = 1'b0;
        #1;
        chk({tag, " cpu_lvl after return"}, int'(cpu_lvl), exp_lvl);
    endtask

    task automatic do_write(string tag, int val, int exp_lvl);
        @(negedge clk);
        ipl_wr = 1'b1;
        ipl_wdata = 3'(val);
        @(negedge clk);
        ipl_wr = 1'b0;
        #1;
        chk({tag, " cpu_lvl after write"}, int'(cpu_lvl), exp_lvl);
    endtask

    task automatic pulse_trap(logic [4:0] m);
        @(negedge clk);
        trap_in = m;
        @(negedge clk);
        trap_in = '0;
        #1;
        chk("R9 no take without boundary", int'(exc_take), 0);
    endtask

    task automatic t_reset;
        #1;
        chk("R10 reset cpu_lvl", int'(cpu_lvl), 0);
        chk("R10 reset no take", int'(exc_take), 0);
        fire("R10 boundary with nothing pending", 1'b0, 0, 0, 0);
    endtask

    task automatic t_tiebreak;
        set_src(3, 0, 1, 1);
        fire("R1 level0 source", 1'b0, 0, 0, 0);
        set_src(5, 2, 1, 1);
        set_src(2, 2, 1, 1);
        fire("R2 equal level lowest index", 1'b1, 10, 24'h18, 2);
        set_src(3, 0, 0, 0); set_src(5, 0, 0, 0); set_src(2, 0, 0, 0);
        do_return("R8 single", 0);
    endtask

    task automatic t_nesting;
        set_src(1, 3, 1, 1);
        set_src(9, 6, 1, 1);
        fire("R1 higher level wins", 1'b1, 17, 24'h26, 6);
        set_src(9, 0, 0, 0);
        set_src(1, 0, 0, 0);
        set_src(4, 6, 1, 1);
        fire("R3 equal to cpu not taken", 1'b0, 0, 0, 6);
        set_src(4, 7, 1, 1);
        fire("R3 higher preempts", 1'b1, 12, 24'h1C, 7);
        set_src(4, 0, 0, 0);
        do_return("R8 lifo inner", 6);
        do_return("R8 lifo outer", 0);
    endtask

    task automatic t_enable;
        set_src(7, 4, 1, 0);
        fire("R9 flag without enable", 1'b0, 0, 0, 0);
        set_src(7, 4, 1, 1);
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R10 no take while boundary low", int'(exc_take), 0);
        fire("R9 flag with enable", 1'b1, 15, 24'h22, 4);
        set_src(7, 0, 0, 0);
        do_return("R8 enable test", 0);
    endtask

    task automatic t_nest_dis;
        nest_dis = 1'b1;
        set_src(0, 1, 1, 1);
        fire("R4 entry locks at 7", 1'b1, 8, 24'h14, 7);
        set_src(0, 0, 0, 0);
        set_src(15, 7, 1, 1);
        fire("R4 level7 blocked", 1'b0, 0, 0, 7);
        set_src(15, 0, 0, 0);
        do_write("R5 write ignored", 3, 7);
        do_return("R4 return unlocks", 0);
        nest_dis = 1'b0;
        do_write("R5 write applies", 3, 3);
        do_return("R8 empty stack", 0);
    endtask

    task automatic t_traps;
        do_write("R6 setup", 7, 7);
        set_src(6, 7, 1, 1);
        pulse_trap(5'b01010);
        fire("R6 lowest trap first", 1'b1, 2, 24'h08, 8);
        fire("R6 nested trap", 1'b1, 4, 24'h0C, 8);
        fire("R6 maskable blocked by trap level", 1'b0, 0, 0, 8);
        do_return("R8 trap inner", 8);
        do_return("R8 trap outer", 7);
        fire("R3 level7 at cpu7", 1'b0, 0, 0, 7);
        do_write("R5 lower", 0, 0);
        fire("R6 maskable after traps", 1'b1, 14, 24'h20, 7);
        set_src(6, 0, 0, 0);
        do_return("R8 after traps", 0);
    endtask

    task automatic t_alt;
        alt_sel = 1'b1;
        pulse_trap(5'b10000);
        fire("R7 alt trap", 1'b1, 5, 24'h8E, 8);
        do_return("R7 alt trap return", 0);
        set_src(0, 2, 1, 1);
        fire("R7 alt maskable", 1'b1, 8, 24'h94, 2);
        set_src(0, 0, 0, 0);
        do_return("R7 alt return", 0);
        alt_sel = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        irq_flag = '0; irq_en = '0; irq_lvl = '0; trap_in = '0;
        nest_dis = 1'b0; alt_sel = 1'b0; boundary = 1'b0; rtn = 1'b0;
        ipl_wr = 1'b0; ipl_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tiebreak();
        t_nesting();
        t_enable();
        t_nest_dis();
        t_traps();
        t_alt();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule